// File: doc/BRIEF.md
# Priority Multicast 4x4 Switching Element

This element switches up to four cells per switching cycle onto four output links. Each input presents a cell with a valid flag, a 3-bit priority, a 2-bit route tag and an opaque payload word. The four links form two groups:

- The upper group holds links 0 and 1.
- The lower group holds links 2 and 3.
- Within each group the lower-numbered link is the regular link and the other is the alternative link.

Requests are served in descending priority. Equal priorities are served in ascending input index. A requesting group hands out its regular link first and its alternative link second. Once both links of a group are taken, any further request for that group is blocked. A cell tagged for both groups is copied onto one link of each group in the same cycle, or it is not sent at all.

Each input has a handshake made of `in_valid` and `in_ack`. `in_ack` plays the role of ready, but it is registered: it reports, one cycle later, whether the cell offered in the previous cycle was switched. A blocked cell gets no acknowledge. Its source must keep offering the same cell, which is the head-of-line hold the queue in front of the element relies on. The output links carry only a valid flag and have no back-pressure: whatever sits on a link with valid high is taken downstream in that cycle. Link assignments and acknowledges are computed combinationally from the inputs and captured together on the rising clock edge.

Top module: `mcast_se4`

## Requirements
- R1: A synchronous reset clears every `out_valid` and every `in_ack` at the next rising edge.
- R2: The tag is bit-coded: bit 0 requests the upper group (links 0/1) and bit 1 requests the lower group (links 2/3). So 2'b01 means upper only, 2'b10 means lower only, and 2'b11 means both. A lone request is granted the regular link (0 for upper, 2 for lower).
- R3: The alternative link of a group (1 or 3) is granted only when that group's regular link is already taken in the same cycle.
- R4: A higher-priority request is served before any lower-priority request, so the regular link of a group carries a priority at least as high as its alternative link.
- R5: Between requests of equal priority, the lower input index is served first.
- R6: A switched cell with tag 2'b11 appears on exactly one link of the upper group and one link of the lower group in the same cycle.
- R7: A tag 2'b11 cell is blocked whole if either group has no free link left when it is served. It places no copy, and the links it would have used stay available to lower-priority requests.
- R8: `in_ack[i]` is high exactly when the cell offered on input i in the previous cycle was placed on at least one link. A cell blocked for lack of links gets `in_ack` low.
- R9: An input with `in_valid` low, or with tag 2'b00, takes no link and gets no acknowledge.
- R10: A link with `out_valid` high carries the source input index on `out_src`, together with that cell's priority and payload. Unassigned links drive `out_valid` low.
- R11: Every result appears on the rising edge after the inputs that caused it, and stays unchanged until that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Switching-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 4 | Per-input cell present |
| in_prio | input | 4 x PRIO_W | Per-input priority, larger value served first |
| in_tag | input | 4 x 2 | Per-input route tag (bit 0 upper group, bit 1 lower group) |
| in_data | input | 4 x DATA_W | Per-input opaque payload |
| in_ack | output | 4 | Registered: cell of previous cycle was switched |
| out_valid | output | 4 | Link carries a cell |
| out_src | output | 4 x 2 | Input index the link's cell came from |
| out_prio | output | 4 x PRIO_W | Priority of the link's cell |
| out_data | output | 4 x DATA_W | Payload of the link's cell |

## Verification
Every link field and every acknowledge is due exactly one rising edge after the inputs that produced it. The bench therefore changes inputs on a falling edge and reads the results on the following falling edge, so exactly one capturing edge lies between stimulus and check. One directed check reads the outputs halfway through the cycle, before that edge, to show that nothing changes early. Another asserts reset while a full load of cells is offered and expects every valid and acknowledge to be cleared one edge later.

// File: rtl/se4_pkg.sv
package se4_pkg;
  localparam int N_PORT = 4;
  localparam int IDX_W  = $clog2(N_PORT);
  localparam int TAG_W  = 2;
  localparam int GRP_LINKS = 2;

  // Route tag bits: bit 0 upper group, bit 1 lower group
  localparam int TAG_UP_BIT = 0;
  localparam int TAG_LO_BIT = 1;

  // Link numbering inside the element
  localparam logic [IDX_W-1:0] LINK_UP_REG = 2'd0;
  localparam logic [IDX_W-1:0] LINK_UP_ALT = 2'd1;
  localparam logic [IDX_W-1:0] LINK_LO_REG = 2'd2;
  localparam logic [IDX_W-1:0] LINK_LO_ALT = 2'd3;
endpackage

// File: rtl/se4_rank.sv
// Produces the service order: order[r] is the input served r-th.
module se4_rank
  import se4_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic [N_PORT-1:0][PRIO_W-1:0] prio,
  output logic [N_PORT-1:0][IDX_W-1:0]  order
);
  logic [N_PORT-1:0][IDX_W-1:0] rank;

  for (genvar i = 0; i < N_PORT; i++) begin : g_rank
    always_comb begin
      logic [IDX_W:0] ahead;
      ahead = '0;
      for (int j = 0; j < N_PORT; j++) begin
        if (j != i) begin
          if ((prio[j] > prio[i]) || ((prio[j] == prio[i]) && (j < i)))
            ahead = ahead + 1'b1;
        end
      end
      rank[i] = ahead[IDX_W-1:0];
    end
  end

  always_comb begin
    order = '0;
    for (int r = 0; r < N_PORT; r++) begin
      for (int i = 0; i < N_PORT; i++) begin
        if (rank[i] == IDX_W'(r)) order[r] = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/se4_alloc.sv
// Walks inputs in service order and hands out group links.
module se4_alloc
  import se4_pkg::*;
(
  input  logic [N_PORT-1:0][IDX_W-1:0] order,
  input  logic [N_PORT-1:0]            want_up,
  input  logic [N_PORT-1:0]            want_lo,
  output logic [N_PORT-1:0]            grant,
  output logic [N_PORT-1:0]            link_on,
  output logic [N_PORT-1:0][IDX_W-1:0] link_src
);
  always_comb begin
    logic [1:0]       used_up;
    logic [1:0]       used_lo;
    logic [IDX_W-1:0] who;
    logic             fits;
    used_up  = '0;
    used_lo  = '0;
    grant    = '0;
    link_on  = '0;
    link_src = '0;
    for (int r = 0; r < N_PORT; r++) begin
      who  = order[r];
      fits = (want_up[who] || want_lo[who]) &&
             (!want_up[who] || (used_up < 2'(GRP_LINKS))) &&
             (!want_lo[who] || (used_lo < 2'(GRP_LINKS)));
      if (fits) begin
        grant[who] = 1'b1;
        if (want_up[who]) begin
          if (used_up == 2'd0) begin
            link_on[LINK_UP_REG]  = 1'b1;
            link_src[LINK_UP_REG] = who;
          end else begin
            link_on[LINK_UP_ALT]  = 1'b1;
            link_src[LINK_UP_ALT] = who;
          end
          used_up = used_up + 2'd1;
        end
        if (want_lo[who]) begin
          if (used_lo == 2'd0) begin
            link_on[LINK_LO_REG]  = 1'b1;
            link_src[LINK_LO_REG] = who;
          end else begin
            link_on[LINK_LO_ALT]  = 1'b1;
            link_src[LINK_LO_ALT] = who;
          end
          used_lo = used_lo + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/mcast_se4.sv
module mcast_se4
  import se4_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter int DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [N_PORT-1:0]                 in_valid,
  input  logic [N_PORT-1:0][PRIO_W-1:0]     in_prio,
  input  logic [N_PORT-1:0][TAG_W-1:0]      in_tag,
  input  logic [N_PORT-1:0][DATA_W-1:0]     in_data,
  output logic [N_PORT-1:0]                 in_ack,
  output logic [N_PORT-1:0]                 out_valid,
  output logic [N_PORT-1:0][IDX_W-1:0]      out_src,
  output logic [N_PORT-1:0][PRIO_W-1:0]     out_prio,
  output logic [N_PORT-1:0][DATA_W-1:0]     out_data
);
  logic [N_PORT-1:0]            want_up, want_lo;
  logic [N_PORT-1:0][IDX_W-1:0] order;
  logic [N_PORT-1:0]            grant;
  logic [N_PORT-1:0]            link_on;
  logic [N_PORT-1:0][IDX_W-1:0] link_src;

  for (genvar i = 0; i < N_PORT; i++) begin : g_req
    assign want_up[i] = in_valid[i] & in_tag[i][TAG_UP_BIT];
    assign want_lo[i] = in_valid[i] & in_tag[i][TAG_LO_BIT];
  end

  se4_rank #(.PRIO_W(PRIO_W)) u_rank (
    .prio  (in_prio),
    .order (order)
  );

  se4_alloc u_alloc (
    .order    (order),
    .want_up  (want_up),
    .want_lo  (want_lo),
    .grant    (grant),
    .link_on  (link_on),
    .link_src (link_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      in_ack    <= '0;
    end else begin
      out_valid <= link_on;
      in_ack    <= grant;
    end
  end

  for (genvar k = 0; k < N_PORT; k++) begin : g_link
    always_ff @(posedge clk) begin
      out_src[k]  <= link_src[k];
      out_prio[k] <= in_prio[link_src[k]];
      out_data[k] <= in_data[link_src[k]];
    end
  end
endmodule

// File: rtl/se4_chk.sv
module se4_chk
  import se4_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter int DATA_W = 16
) (
  input logic                          clk,
  input logic                          rst,
  input logic [N_PORT-1:0]             in_valid,
  input logic [N_PORT-1:0][TAG_W-1:0]  in_tag,
  input logic [N_PORT-1:0]             in_ack,
  input logic [N_PORT-1:0]             out_valid,
  input logic [N_PORT-1:0][IDX_W-1:0]  out_src,
  input logic [N_PORT-1:0][PRIO_W-1:0] out_prio,
  input logic [N_PORT-1:0][DATA_W-1:0] out_data
);
  logic                           rst_q;
  logic [N_PORT-1:0]              valid_q;
  logic [N_PORT-1:0][TAG_W-1:0]   tag_q;

  always_ff @(posedge clk) begin
    rst_q   <= rst;
    valid_q <= in_valid;
    tag_q   <= in_tag;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (out_valid == '0 && in_ack == '0));

  // R3
  up_alt_after_reg_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid[LINK_UP_ALT] |-> out_valid[LINK_UP_REG]);

  // R3
  lo_alt_after_reg_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid[LINK_LO_ALT] |-> out_valid[LINK_LO_REG]);

  // R4
  up_prio_order_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid[LINK_UP_ALT] |-> (out_prio[LINK_UP_ALT] <= out_prio[LINK_UP_REG]));

  // R4
  lo_prio_order_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid[LINK_LO_ALT] |-> (out_prio[LINK_LO_ALT] <= out_prio[LINK_LO_REG]));

  for (genvar i = 0; i < N_PORT; i++) begin : g_in
    logic [N_PORT-1:0] hits;
    for (genvar k = 0; k < N_PORT; k++) begin : g_hit
      assign hits[k] = out_valid[k] && (out_src[k] == IDX_W'(i));
    end

    // R8
    ack_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
      in_ack[i] |-> (valid_q[i] && tag_q[i] != 2'b00));

    // R6
    copy_count_chk: assert property (@(posedge clk) disable iff (rst)
      in_ack[i] |-> ($countones(hits) == ((tag_q[i] == 2'b11) ? 2 : 1)));

    // R7
    no_partial_copy_chk: assert property (@(posedge clk) disable iff (rst)
      !in_ack[i] |-> (hits == '0));
  end

  for (genvar k = 0; k < N_PORT; k++) begin : g_out
    // R10
    link_source_acked_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid[k] |-> in_ack[out_src[k]]);

    // R2
    link_group_match_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid[k] |-> tag_q[out_src[k]][k / 2]);
  end
endmodule

bind mcast_se4 se4_chk #(.PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_tag    (in_tag),
  .in_ack    (in_ack),
  .out_valid (out_valid),
  .out_src   (out_src),
  .out_prio  (out_prio),
  .out_data  (out_data)
);

// File: tb/mcast_se4_test.sv
`timescale 1ns/1ps
module mcast_se4_test;
  localparam int PW = 3;
  localparam int DW = 16;
  localparam int NV = 11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [3:0]        in_valid = '0;
  logic [3:0][PW-1:0] in_prio = '0;
  logic [3:0][1:0]   in_tag = '0;
  logic [3:0][DW-1:0] in_data = '0;
  logic [3:0]        in_ack;
  logic [3:0]        out_valid;
  logic [3:0][1:0]   out_src;
  logic [3:0][PW-1:0] out_prio;
  logic [3:0][DW-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mcast_se4 #(.PRIO_W(PW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_prio(in_prio),
    .in_tag(in_tag), .in_data(in_data), .in_ack(in_ack),
    .out_valid(out_valid), .out_src(out_src), .out_prio(out_prio),
    .out_data(out_data)
  );

  // {valid[3:0], prio3..prio0, tag3..tag0, exp_ov[3:0], src link3..link0, exp_ack[3:0]}
  localparam logic [39:0] VEC [NV] = '{
    // R2: upper alone -> regular link 0
    {4'b0001, 3'd0,3'd0,3'd0,3'd0, 2'b00,2'b00,2'b00,2'b01, 4'b0001, 2'd0,2'd0,2'd0,2'd0, 4'b0001},
    // R2: lower alone -> regular link 2
    {4'b0100, 3'd0,3'd5,3'd0,3'd0, 2'b00,2'b10,2'b00,2'b00, 4'b0100, 2'd0,2'd2,2'd0,2'd0, 4'b0100},
    // R3 R4: higher prio input 1 takes regular link
    {4'b0011, 3'd0,3'd0,3'd6,3'd1, 2'b00,2'b00,2'b01,2'b01, 4'b0011, 2'd0,2'd0,2'd0,2'd1, 4'b0011},
    // R5 R8: equal prio, index order, third blocked
    {4'b0111, 3'd0,3'd3,3'd3,3'd3, 2'b00,2'b01,2'b01,2'b01, 4'b0011, 2'd0,2'd0,2'd1,2'd0, 4'b0011},
    // R6: replicate alone onto links 0 and 2
    {4'b1000, 3'd2,3'd0,3'd0,3'd0, 2'b11,2'b00,2'b00,2'b00, 4'b0101, 2'd0,2'd3,2'd0,2'd3, 4'b1000},
    // R7: lower full, replicate blocked whole, later upper still served
    {4'b1111, 3'd4,3'd5,3'd6,3'd7, 2'b01,2'b11,2'b10,2'b10, 4'b1101, 2'd1,2'd0,2'd0,2'd3, 4'b1011},
    // R9: tag 00 and invalid input ignored
    {4'b0011, 3'd0,3'd7,3'd7,3'd0, 2'b00,2'b01,2'b00,2'b01, 4'b0001, 2'd0,2'd0,2'd0,2'd0, 4'b0001},
    // R6 R8: four replicates, two fit
    {4'b1111, 3'd4,3'd3,3'd2,3'd1, 2'b11,2'b11,2'b11,2'b11, 4'b1111, 2'd2,2'd3,2'd2,2'd3, 4'b1100},
    // R4 R6: unicast and replicate mixed
    {4'b0111, 3'd0,3'd7,3'd5,3'd2, 2'b00,2'b01,2'b11,2'b01, 4'b0111, 2'd0,2'd1,2'd1,2'd2, 4'b0110},
    // R9: nothing valid
    {4'b0000, 3'd0,3'd0,3'd0,3'd0, 2'b01,2'b01,2'b01,2'b01, 4'b0000, 2'd0,2'd0,2'd0,2'd0, 4'b0000},
    // R3 R5: lower group tie, alternative link 3, input 3 blocked
    {4'b1011, 3'd4,3'd0,3'd4,3'd4, 2'b10,2'b00,2'b10,2'b10, 4'b1100, 2'd1,2'd0,2'd0,2'd0, 4'b0011}
  };

  function automatic logic [DW-1:0] dat(int v, int i);
    return DW'(16'h5A00 + v * 16 + i);
  endfunction

  task automatic drive(int v);
    logic [39:0] e;
    e = VEC[v];
    in_valid = e[39:36];
    in_prio  = e[35:24];
    in_tag   = e[23:16];
    for (int i = 0; i < 4; i++) in_data[i] = dat(v, i);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_vec(int v);
    logic [39:0] e;
    logic [3:0][1:0] es;
    logic [3:0][PW-1:0] pp;
    e  = VEC[v];
    pp = e[35:24];
    es = e[11:4];
    check("R8", 32'(in_ack), 32'(e[3:0]), $sformatf("vec%0d ack", v));
    check("R2", 32'(out_valid), 32'(e[15:12]), $sformatf("vec%0d out_valid", v));
    for (int k = 0; k < 4; k++) begin
      if (e[12 + k]) begin
        check("R10", 32'(out_src[k]), 32'(es[k]), $sformatf("vec%0d link%0d src", v, k));
        check("R10", 32'(out_prio[k]), 32'(pp[es[k]]), $sformatf("vec%0d link%0d prio", v, k));
        check("R10", 32'(out_data[k]), 32'(dat(v, int'(es[k]))), $sformatf("vec%0d link%0d data", v, k));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", 32'(out_valid), 32'h0, "reset out_valid");
    check("R1", 32'(in_ack), 32'h0, "reset ack");
    rst = 1'b0;

    // R11: result not visible before the capturing edge
    drive(0);
    #5;
    check("R11", 32'(out_valid), 32'h0, "early out_valid");
    check("R11", 32'(in_ack), 32'h0, "early ack");
    @(negedge clk);
    check_vec(0);

    for (int v = 0; v < NV; v++) begin
      drive(v);
      @(negedge clk);
      check_vec(v);
    end

    // R11: held inputs give a stable result across edges
    drive(7);
    @(negedge clk);
    @(negedge clk);
    check_vec(7);

    // R1: reset while a full load is offered
    rst = 1'b1;
    @(negedge clk);
    check("R1", 32'(out_valid), 32'h0, "mid-run reset out_valid");
    check("R1", 32'(in_ack), 32'h0, "mid-run reset ack");
    rst = 1'b0;
    @(negedge clk);
    check_vec(7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule